// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Decimal Readout

This block multiplies two unsigned N-bit operands over several clock cycles. It uses one conditional add per multiplier bit. The finished 2N-bit product is also given as packed binary-coded decimal. A combinational shift-and-add-3 network forms the decimal digits from the product. The block raises one flag once the binary and decimal results are both valid.

A single `start` level drives each operation. While `start` is low, the block loads the operands and clears its results. Raising `start` runs the multiplication. The results then hold for as long as `start` stays high. A controller in the top module owns the sequencing and has four named states:

- `ST_IDLE`: the state after reset. `start` held high here does nothing.
- `ST_LOAD`: operands are being captured.
- `ST_MUL`: multiply steps are running.
- `ST_DONE`: the results are presented.

The transitions are:

- **any→LOAD** when `start` is low.
- **IDLE→IDLE** while `start` stays high.
- **LOAD→MUL** on the first step, when more than one step is still due.
- **LOAD→DONE** or **MUL→DONE** on the last step.
- **MUL→MUL** on every other step.
- **DONE→DONE** while `start` stays high.

Top module: `seq_bcd_multiplier`

## Requirements
- R1: While `rst` is high, and afterwards until an operation completes, `finished`, `product` and `bcd_product` are all zero.
- R2: On a clock edge with `start` low, the operands are captured. On the next cycle `finished` is 0 and both result outputs are 0.
- R3: When `finished` is 1, `product` equals `op_a * op_b` as a full 2N-bit unsigned value, without loss for the largest operands. The operands are those captured on the last edge that had `start` low.
- R4: `finished` rises exactly N clock edges after the first edge with `start` high that follows a load, and not earlier.
- R5: When `finished` is 1, `bcd_product` is packed decimal. It holds floor(2N/3)+1 digits of 4 bits each. Bits [4k+3:4k] hold decimal digit k of the product, with k=0 the units digit. Digits above the most significant nonzero digit are 0, and every digit is in 0 to 9.
- R6: While `start` stays high after `finished` rises, `finished` stays 1 and both results are unchanged, whatever the operand inputs do.
- R7: Changes on `op_a` or `op_b` while `start` is high have no effect on the result.
- R8: Driving `start` low after completion clears `finished` and both results on the next edge, and arms a new operation.
- R9: If `start` is already high when reset ends, no operation runs and the outputs stay zero until `start` has been low for at least one edge.
- R10: An operand of zero gives a product of 0, BCD of 0, and the same N-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Low: load operands. High: run, then hold results |
| op_a | input | N | Multiplicand operand, unsigned |
| op_b | input | N | Multiplier operand, unsigned |
| product | output | 2N | Binary product, valid when `finished` is 1 |
| bcd_product | output | 4*(floor(2N/3)+1) | Packed decimal product, units digit in bits [3:0] |
| finished | output | 1 | High while both results are valid |

## Verification
After an edge with `start` low, the cleared outputs are due on the next cycle. The bench samples them at the following falling edge. After `start` rises, `finished` must still be 0 at the falling edge after N-1 rising edges. `finished`, the binary product and the decimal product are all due together right after the N-th rising edge. The bench samples all three at that falling edge against its own product and digit-by-digit decimal model. It keeps sampling for further cycles with `start` high while the operands change, to show the results hold.

// File: rtl/bcdmul_pkg.sv
package bcdmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_MUL  = 2'd2,
        ST_DONE = 2'd3
    } mul_state_t;
endpackage

// File: rtl/shift_add_core.sv
module shift_add_core #(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic [2*N-1:0] acc,
    output logic           last_step
);
    localparam int W  = 2 * N;
    localparam int CW = $clog2(N + 1);

    logic [W-1:0]  mcand;
    logic [N-1:0]  mplier;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand  <= '0;
            mplier <= '0;
            acc    <= '0;
            left   <= '0;
        end else if (load) begin
            mcand  <= {{N{1'b0}}, a_in};
            mplier <= b_in;
            acc    <= '0;
            left   <= CW'(N);
        end else if (step) begin
            if (mplier[0]) begin
                acc <= acc + mcand;
            end
            mplier <= mplier >> 1;
            mcand  <= mcand << 1;
            left   <= left - 1'b1;
        end
    end

    assign last_step = (left == CW'(1));

    // R4: the controller never steps once the count is used up
    a_r4_no_extra_step: assert property (@(posedge clk) disable iff (rst)
        step |-> left != '0);

    // R4: each step removes exactly one pending bit
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> left == $past(left) - 1'b1);

    // R2: a load leaves a clean accumulator and a full count
    a_r2_load_init: assert property (@(posedge clk) disable iff (rst)
        load |=> (acc == '0) && (left == CW'(N)));
endmodule

// File: rtl/dd_bin2bcd.sv
module dd_bin2bcd #(
    parameter int W      = 16,
    parameter int DIGITS = W / 3 + 1
) (
    input  logic [W-1:0]        bin,
    output logic [4*DIGITS-1:0] bcd
);
    localparam int BW = 4 * DIGITS;
    localparam int SW = BW + W;

    for (genvar i = 0; i < W; i++) begin : g_stage
        logic [SW-1:0] din;
        logic [SW-1:0] adj;
        if (i == 0) begin : g_first
            assign din = {{BW{1'b0}}, bin};
        end else begin : g_next
            assign din = g_stage[i-1].adj << 1;
        end
        always_comb begin
            adj = din;
            for (int d = 0; d < DIGITS; d++) begin
                if (adj[W+4*d +: 4] > 4'd4) begin
                    adj[W+4*d +: 4] = adj[W+4*d +: 4] + 4'd3;
                end
            end
        end
    end

    logic [SW-1:0] final_sh;
    assign final_sh = g_stage[W-1].adj << 1;
    assign bcd      = final_sh[SW-1:W];

    // R5: every produced digit is a legal decimal digit
    always_comb begin
        for (int d = 0; d < DIGITS; d++) begin
            a_r5_digit_range: assert (bcd[4*d +: 4] < 4'd10);
        end
    end
endmodule

// File: rtl/seq_bcd_multiplier.sv
module seq_bcd_multiplier
    import bcdmul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [N-1:0]                 op_a,
    input  logic [N-1:0]                 op_b,
    output logic [2*N-1:0]               product,
    output logic [4*((2*N)/3+1)-1:0]     bcd_product,
    output logic                         finished
);
    localparam int W      = 2 * N;
    localparam int DIGITS = W / 3 + 1;
    localparam int BW     = 4 * DIGITS;

    mul_state_t state, nxt;
    logic load, step, last_step;
    logic [W-1:0]  acc;
    logic [BW-1:0] acc_bcd;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!start) begin
            nxt = ST_LOAD;
        end else begin
            unique case (state)
                ST_IDLE: nxt = ST_IDLE;
                ST_LOAD: nxt = last_step ? ST_DONE : ST_MUL;
                ST_MUL:  nxt = last_step ? ST_DONE : ST_MUL;
                ST_DONE: nxt = ST_DONE;
            endcase
        end
    end

    always_comb begin
        load        = !start;
        step        = start && ((state == ST_LOAD) || (state == ST_MUL));
        finished    = (state == ST_DONE);
        product     = finished ? acc : '0;
        bcd_product = finished ? acc_bcd : '0;
    end

    shift_add_core #(.N(N)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step),
        .a_in     (op_a),
        .b_in     (op_b),
        .acc      (acc),
        .last_step(last_step)
    );

    dd_bin2bcd #(.W(W), .DIGITS(DIGITS)) u_conv (
        .bin(acc),
        .bcd(acc_bcd)
    );

    // R6: completed results are frozen while start stays high
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (finished && start) |=> finished && $stable(product) && $stable(bcd_product));

    // R2 / R8: a low start clears the outputs on the next cycle
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        !start |=> !finished && (product == '0) && (bcd_product == '0));

    // R4: completion is only ever reached while start is high
    a_r4_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(finished) |-> $past(start));

    // R1: outputs are zero whenever no result is presented
    a_r1_quiet: assert property (@(posedge clk) disable iff (rst)
        !finished |-> (product == '0) && (bcd_product == '0));
endmodule

// File: tb/sim_seq_bcd_multiplier.sv
module sim_seq_bcd_multiplier;
    localparam int N  = 8;
    localparam int W  = 2 * N;
    localparam int DG = W / 3 + 1;
    localparam int BW = 4 * DG;

    logic clk = 1'b0;
    logic rst, start;
    logic [N-1:0]  op_a, op_b;
    logic [W-1:0]  product;
    logic [BW-1:0] bcd_product;
    logic          finished;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    seq_bcd_multiplier #(.N(N)) u0 (
        .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
        .product(product), .bcd_product(bcd_product), .finished(finished)
    );

    function automatic logic [BW-1:0] ref_bcd(input longint unsigned v);
        logic [BW-1:0] r = '0;
        for (int k = 0; k < DG; k++) begin
            r[4*k +: 4] = 4'(v % 10);
            v = v / 10;
        end
        return r;
    endfunction

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [N-1:0] a, input logic [N-1:0] b, input bit scramble);
        longint unsigned p;
        @(negedge clk);
        start = 1'b0; op_a = a; op_b = b;
        @(posedge clk); @(negedge clk);
        chk("R2 finished after load", finished, 0);
        chk("R2 product after load", product, 0);
        start = 1'b1;
        p = longint'(a) * longint'(b);
        for (int k = 1; k < N; k++) begin
            @(posedge clk); @(negedge clk);
            if (scramble) begin op_a = N'($urandom); op_b = N'($urandom); end
        end
        chk("R4 finished not early", finished, 0);
        @(posedge clk); @(negedge clk);
        chk("R4 finished after N edges", finished, 1);
        chk("R3 binary product", product, p);
        chk("R5 decimal product", bcd_product, ref_bcd(p));
        for (int k = 0; k < 2; k++) begin
            op_a = N'($urandom); op_b = N'($urandom);
            @(posedge clk); @(negedge clk);
        end
        chk("R6 hold finished", finished, 1);
        chk("R6 hold product", product, p);
        chk("R6 hold decimal", bcd_product, ref_bcd(p));
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        rst = 1'b1; start = 1'b1; op_a = 8'd9; op_b = 8'd9;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 finished in reset", finished, 0);
        chk("R1 product in reset", product, 0);
        chk("R1 decimal in reset", bcd_product, 0);
        rst = 1'b0;
        repeat (N + 3) @(posedge clk);
        @(negedge clk);
        chk("R9 no run without low start", finished, 0);
        chk("R9 product stays zero", product, 0);

        run_op(8'd26, 8'd30, 1'b0);   // 780
        chk("R5 digits 7,8,0", bcd_product, 24'h000780);
        run_op(8'd13, 8'd13, 1'b1);   // 169, operands scrambled: R7
        chk("R7 scrambled operands ignored", product, 169);
        run_op(8'd255, 8'd255, 1'b0);
        chk("R3 max operands", bcd_product, 24'h065025);
        run_op(8'd0, 8'd201, 1'b0);
        chk("R10 zero multiplicand", product, 0);
        run_op(8'd177, 8'd0, 1'b1);
        chk("R10 zero multiplier", bcd_product, 0);
        run_op(8'd1, 8'd1, 1'b0);

        @(negedge clk);
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8 clear finished", finished, 0);
        chk("R8 clear decimal", bcd_product, 0);

        for (int t = 0; t < 40; t++) begin
            run_op(N'($urandom), N'($urandom), 1'(t % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule